// File: doc/BRIEF.md
# DMA Channel Request and Transfer Control

This block is a single DMA channel. Software programs it through a 16-bit control word made of two byte lanes. The lower lane holds the channel enable, the pending-request flag, the operating mode, the item size, the two address-direction bits and a 2-bit trigger select. The upper lane holds a 4-bit extended trigger select. Hardware events reach the flag through a two-level selector. Three codes of the trigger select pick software, the serial-transmit event or the serial-receive event. The fourth code hands the choice to the extended field, which picks one of ten event lines.

While the channel is enabled, a pending request launches one transfer on a valid/ready interface that carries the current source and destination addresses and the item size. The flag clears when the transfer starts. After each completed transfer, each address either stays fixed or advances by the item size.

A transfer count is captured when the channel is switched on. In normal mode the channel switches itself off when the count runs out. In ring mode both addresses return to their captured start values, the count is reloaded and the channel stays on.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, reg_rdata_o reads 0x0000 and xfer_valid_o is low.
- R2: Bits [11:8] of the control word store the extended select, written through byte lane 1. Bits [15:12] always read 0, whatever is written to them.
- R3: The control word uses these bit positions: bit 0 enable, bit 1 pending flag, bit 2 ring mode, bit 3 byte size, bit 4 source increment, bit 5 destination increment, bits [7:6] trigger select. A rising edge on the selected request line sets the pending flag: select 01 uses tx_req_i, select 10 uses rx_req_i, and select 11 uses ext_req_i[extended select]. An edge on a line that is not selected has no effect, and a line held high does not set the flag again once it has been cleared.
- R4: Extended select codes 10 to 15 connect no line, so no event can set the pending flag under them.
- R5: A lane-0 write with bit 1 at 0 clears the pending flag. A write with bit 1 at 1 leaves the flag as it was.
- R6: A lane-0 write with select 00 and enable 1 sets the pending flag. With any other select, such a write does not set it, and under select 00 hardware events do not set it.
- R7: No transfer starts while the enable bit is 0, even with the pending flag set.
- R8: With the channel enabled and the flag set, xfer_valid_o rises one cycle later and the flag clears in that same cycle. xfer_valid_o, xfer_src_o and xfer_dst_o then hold until xfer_ready_i is sampled high.
- R9: A size bit of 1 gives byte transfers (xfer_byte_o=1, step 1). A size bit of 0 gives 16-bit transfers (xfer_byte_o=0, step 2).
- R10: After each completed transfer, each address advances by the step when its increment bit is 1 and stays unchanged when the bit is 0.
- R11: In normal mode (bit 2 = 0), the enable bit clears when the transfer that exhausts the captured count completes.
- R12: In ring mode, the transfer that exhausts the count returns both addresses to their start values and reloads the count, and the enable bit stays 1.
- R13: src_base_i, dst_base_i and count_i are captured only by a lane-0 write that turns the enable bit from 0 to 1. Later changes on these inputs have no effect until the next such write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 2 | Byte-lane write strobes for the control word |
| reg_wdata_i | input | 16 | Control word write data |
| reg_rdata_o | output | 16 | Control word read data |
| tx_req_i | input | 1 | Serial transmitter buffer-empty event |
| rx_req_i | input | 1 | Serial receive event |
| ext_req_i | input | NEXT | Extended event lines |
| src_base_i | input | AW | Source start address |
| dst_base_i | input | AW | Destination start address |
| count_i | input | CW | Transfers per block |
| xfer_valid_o | output | 1 | Transfer request |
| xfer_ready_i | input | 1 | Transfer accepted and completed |
| xfer_src_o | output | AW | Current source address |
| xfer_dst_o | output | AW | Current destination address |
| xfer_byte_o | output | 1 | Item size: 1 byte, 0 halfword |

## Verification
The trigger selector is tried with pulses on the selected line, pulses on a neighbouring line that is not selected, and pulses on every line at once under prohibited extended codes and under software select. These patterns separate a correct decode from an off-by-one index, a missing range check and a selector that ignores the select code. Transfer runs compare fixed against incrementing addresses and byte against halfword steps, so a wrong step or a wrong direction bit shows up as a wrong address. Normal and ring runs end one count apart, which exposes a miscounted end, a wrap to the live inputs instead of the captured bases, and an enable that fails to drop. A stalled ready shows whether the request and its addresses hold.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned PEND_BIT = 1;
  localparam int unsigned RING_BIT = 2;
  localparam int unsigned BYTE_BIT = 3;
  localparam int unsigned SINC_BIT = 4;
  localparam int unsigned DINC_BIT = 5;
  localparam int unsigned SEL_LSB  = 6;
  localparam int unsigned EXT_LSB  = 8;
  localparam int unsigned EXT_W    = 4;
  localparam int unsigned REG_W    = 16;

  typedef enum logic [1:0] {
    SRC_SW  = 2'b00,
    SRC_TX  = 2'b01,
    SRC_RX  = 2'b10,
    SRC_EXT = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic             en;
    logic             ring;
    logic             byte_sz;
    logic             sinc;
    logic             dinc;
    src_sel_e         sel;
    logic [EXT_W-1:0] ext;
  } ctrl_t;

  typedef enum logic {ST_IDLE, ST_BUSY} xfer_st_e;
endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel
  import dma_chan_pkg::*;
#(
  parameter int unsigned NEXT = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_req_i,
  input  logic             rx_req_i,
  input  logic [NEXT-1:0]  ext_req_i,
  input  src_sel_e         sel_i,
  input  logic [EXT_W-1:0] ext_sel_i,
  output logic             hw_set_o
);
  localparam int unsigned NIN = NEXT + 2;

  logic [NIN-1:0]  raw, prev_q, rise;
  logic [NEXT-1:0] ext_rise;
  logic            ext_hit;

  assign raw = {ext_req_i, rx_req_i, tx_req_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= raw;
  end

  // edge detect before the mux so a select change cannot fake an edge
  assign rise     = raw & ~prev_q;
  assign ext_rise = rise[NIN-1:2];

  always_comb begin
    ext_hit = 1'b0;
    for (int i = 0; i < NEXT; i++) begin
      if (ext_sel_i == EXT_W'(i)) ext_hit = ext_rise[i];
    end
  end

  always_comb begin
    unique case (sel_i)
      SRC_TX:  hw_set_o = rise[0];
      SRC_RX:  hw_set_o = rise[1];
      SRC_EXT: hw_set_o = ext_hit;
      default: hw_set_o = 1'b0;
    endcase
  end

  AST_PROHIBITED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SRC_EXT && ext_sel_i >= EXT_W'(NEXT)) |-> !hw_set_o); // R4
  AST_SW_NO_HW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SRC_SW) |-> !hw_set_o); // R6
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_chan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             hw_set_i,
  input  logic             start_i,
  input  logic             end_i,
  output ctrl_t            ctrl_o,
  output logic             pend_o,
  output logic             load_o,
  output logic [REG_W-1:0] rdata_o
);
  ctrl_t ctrl_q;
  logic  pend_q, sw_start, pend_set, pend_clr;
  logic  unused_hi;

  assign unused_hi = ^wdata_i[REG_W-1:EXT_LSB+EXT_W];

  assign sw_start = we_i[0] && wdata_i[EN_BIT]
                 && (src_sel_e'(wdata_i[SEL_LSB+:2]) == SRC_SW);
  assign load_o   = we_i[0] && wdata_i[EN_BIT] && !ctrl_q.en;
  assign pend_set = hw_set_i | sw_start;
  assign pend_clr = (we_i[0] && !wdata_i[PEND_BIT]) | start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (we_i[0]) begin
        ctrl_q.en      <= wdata_i[EN_BIT];
        ctrl_q.ring    <= wdata_i[RING_BIT];
        ctrl_q.byte_sz <= wdata_i[BYTE_BIT];
        ctrl_q.sinc    <= wdata_i[SINC_BIT];
        ctrl_q.dinc    <= wdata_i[DINC_BIT];
        ctrl_q.sel     <= src_sel_e'(wdata_i[SEL_LSB+:2]);
      end else if (end_i) begin
        ctrl_q.en      <= 1'b0;
      end
      if (we_i[1]) ctrl_q.ext <= wdata_i[EXT_LSB+:EXT_W];
    end
  end

  // set beats clear when both land in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_set | (pend_q & ~pend_clr);
  end

  always_comb begin
    rdata_o                    = '0;
    rdata_o[EN_BIT]            = ctrl_q.en;
    rdata_o[PEND_BIT]          = pend_q;
    rdata_o[RING_BIT]          = ctrl_q.ring;
    rdata_o[BYTE_BIT]          = ctrl_q.byte_sz;
    rdata_o[SINC_BIT]          = ctrl_q.sinc;
    rdata_o[DINC_BIT]          = ctrl_q.dinc;
    rdata_o[SEL_LSB+:2]        = ctrl_q.sel;
    rdata_o[EXT_LSB+:EXT_W]    = ctrl_q.ext;
  end

  assign ctrl_o = ctrl_q;
  assign pend_o = pend_q;

  AST_W1_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i[0] && wdata_i[PEND_BIT] && !hw_set_i && !start_i && !sw_start)
      |=> pend_q == $past(pend_q)); // R5
  AST_W0_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i[0] && !wdata_i[PEND_BIT] && !hw_set_i && !sw_start) |=> !pend_q); // R5
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !hw_set_i && !sw_start) |=> !pend_q); // R8
endmodule

// File: rtl/dma_xfer_eng.sv
module dma_xfer_eng
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctrl_t         ctrl_i,
  input  logic          pend_i,
  input  logic          load_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [CW-1:0] count_i,
  input  logic          ready_i,
  output logic          start_o,
  output logic          end_o,
  output logic          valid_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          byte_o
);
  xfer_st_e      st_q;
  logic [AW-1:0] src_q, dst_q, src_base_q, dst_base_q, step;
  logic [CW-1:0] cnt_q, cnt_base_q;
  logic          done, last, wrap;
  logic          unused_ctrl;

  assign unused_ctrl = ^{ctrl_i.sel, ctrl_i.ext};

  assign start_o = (st_q == ST_IDLE) && ctrl_i.en && pend_i;
  assign done    = (st_q == ST_BUSY) && ready_i;
  assign last    = (cnt_q == CW'(1));
  assign wrap    = last && ctrl_i.ring;
  assign end_o   = done && last && !ctrl_i.ring;
  assign step    = ctrl_i.byte_sz ? AW'(1) : AW'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      st_q <= ST_IDLE;
    else if (start_o) st_q <= ST_BUSY;
    else if (done)    st_q <= ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q      <= '0;
      dst_q      <= '0;
      src_base_q <= '0;
      dst_base_q <= '0;
      cnt_q      <= '0;
      cnt_base_q <= '0;
    end else if (load_i) begin
      src_q      <= src_base_i;
      dst_q      <= dst_base_i;
      src_base_q <= src_base_i;
      dst_base_q <= dst_base_i;
      cnt_q      <= count_i;
      cnt_base_q <= count_i;
    end else if (done) begin
      if (wrap) begin
        src_q <= src_base_q;
        dst_q <= dst_base_q;
        cnt_q <= cnt_base_q;
      end else begin
        if (ctrl_i.sinc) src_q <= src_q + step;
        if (ctrl_i.dinc) dst_q <= dst_q + step;
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign valid_o = (st_q == ST_BUSY);
  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign byte_o  = ctrl_i.byte_sz;

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !load_i)
      |=> valid_o && $stable(src_o) && $stable(dst_o)); // R8
  AST_EN_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(ctrl_i.en)); // R7
  AST_RING_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && wrap && !load_i)
      |=> (src_o == src_base_q) && (dst_o == dst_base_q)); // R12
  AST_SRC_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !wrap && !ctrl_i.sinc && !load_i) |=> src_o == $past(src_o)); // R10
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int unsigned NEXT = 10,
  parameter int unsigned AW   = 32,
  parameter int unsigned CW   = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      reg_we_i,
  input  logic [15:0]     reg_wdata_i,
  output logic [15:0]     reg_rdata_o,
  input  logic            tx_req_i,
  input  logic            rx_req_i,
  input  logic [NEXT-1:0] ext_req_i,
  input  logic [AW-1:0]   src_base_i,
  input  logic [AW-1:0]   dst_base_i,
  input  logic [CW-1:0]   count_i,
  output logic            xfer_valid_o,
  input  logic            xfer_ready_i,
  output logic [AW-1:0]   xfer_src_o,
  output logic [AW-1:0]   xfer_dst_o,
  output logic            xfer_byte_o
);
  ctrl_t ctrl;
  logic  hw_set, pend, load, start, blk_end;

  dma_req_sel #(.NEXT(NEXT)) i_req_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_req_i  (tx_req_i),
    .rx_req_i  (rx_req_i),
    .ext_req_i (ext_req_i),
    .sel_i     (ctrl.sel),
    .ext_sel_i (ctrl.ext),
    .hw_set_o  (hw_set)
  );

  dma_ctl_regs i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .hw_set_i (hw_set),
    .start_i  (start),
    .end_i    (blk_end),
    .ctrl_o   (ctrl),
    .pend_o   (pend),
    .load_o   (load),
    .rdata_o  (reg_rdata_o)
  );

  dma_xfer_eng #(.AW(AW), .CW(CW)) i_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl),
    .pend_i     (pend),
    .load_i     (load),
    .src_base_i (src_base_i),
    .dst_base_i (dst_base_i),
    .count_i    (count_i),
    .ready_i    (xfer_ready_i),
    .start_o    (start),
    .end_o      (blk_end),
    .valid_o    (xfer_valid_o),
    .src_o      (xfer_src_o),
    .dst_o      (xfer_dst_o),
    .byte_o     (xfer_byte_o)
  );

  AST_NORMAL_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_end && !reg_we_i[0]) |=> !reg_rdata_o[EN_BIT]); // R11
  AST_HI_NIBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i[1] |=> reg_rdata_o[15:12] == 4'h0); // R2
endmodule

// File: tb/test_dma_chan_ctl.sv
module test_dma_chan_ctl;
  localparam int NEXT = 10;
  localparam int AW   = 32;
  localparam int CW   = 16;

  logic            clk = 0, rst_n = 0;
  logic [1:0]      we = '0;
  logic [15:0]     wdata = '0, rdata;
  logic            tx = 0, rx = 0;
  logic [NEXT-1:0] ext = '0;
  logic [AW-1:0]   sbase = '0, dbase = '0, src, dst;
  logic [CW-1:0]   cnt = '0;
  logic            valid, ready = 1, byte_o;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  dma_chan_ctl #(.NEXT(NEXT), .AW(AW), .CW(CW)) i_dma_chan_ctl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .tx_req_i(tx), .rx_req_i(rx), .ext_req_i(ext),
    .src_base_i(sbase), .dst_base_i(dbase), .count_i(cnt),
    .xfer_valid_o(valid), .xfer_ready_i(ready), .xfer_src_o(src),
    .xfer_dst_o(dst), .xfer_byte_o(byte_o));

  // {sel[1:0], ext[3:0], pin[3:0] (0 tx,1 rx,2+k ext k,15 all), expect}
  localparam logic [10:0] VEC [10] = '{
    {2'b01, 4'd0,  4'd0,  1'b1},
    {2'b01, 4'd0,  4'd1,  1'b0},
    {2'b10, 4'd0,  4'd1,  1'b1},
    {2'b10, 4'd0,  4'd0,  1'b0},
    {2'b11, 4'd0,  4'd2,  1'b1},
    {2'b11, 4'd5,  4'd7,  1'b1},
    {2'b11, 4'd9,  4'd11, 1'b1},
    {2'b11, 4'd9,  4'd10, 1'b0},
    {2'b11, 4'd12, 4'd15, 1'b0},
    {2'b00, 4'd0,  4'd15, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    we = be; wdata = d;
    @(negedge clk);
    we = '0; wdata = '0;
  endtask

  task automatic pulse(input logic [3:0] pin);
    if (pin == 4'd15) begin tx = 1; rx = 1; ext = '1; end
    else if (pin == 4'd0) tx = 1;
    else if (pin == 4'd1) rx = 1;
    else ext[pin-2] = 1'b1;
    wt(1);
    tx = 0; rx = 0; ext = '0;
    wt(1);
  endtask

  initial begin
    #(8 * 200000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    wt(2);
    chk("R1 rdata", rdata, 16'h0000);
    chk("R1 valid", valid, 0);
    rst_n = 1;
    wt(1);

    // R2 upper lane
    wr(2'b10, 16'hFA00);
    chk("R2 upper", rdata[15:8], 8'h0A);

    // R3/R4 selector table
    foreach (VEC[i]) begin
      wr(2'b10, {4'h0, VEC[i][8:5], 8'h00});
      wr(2'b01, {VEC[i][10:9], 6'b0});
      chk("R5 clear before pulse", rdata[1], 0);
      pulse(VEC[i][4:1]);
      chk((VEC[i][10:9] == 2'b11 && VEC[i][8:5] > 9) ? "R4 prohibited" :
          (VEC[i][10:9] == 2'b00) ? "R6 sw select ignores hw" : "R3 select",
          rdata[1], VEC[i][0]);
    end

    // R3 held level, R5 write-1 keeps, write-0 clears
    wr(2'b01, 16'h0040);
    tx = 1; wt(1);
    chk("R3 edge sets", rdata[1], 1);
    wr(2'b01, 16'h0042);
    chk("R5 write 1 keeps", rdata[1], 1);
    wr(2'b01, 16'h0040);
    wt(2);
    chk("R3 held level no reset", rdata[1], 0);
    tx = 0;

    // R6 start not honoured for non-software select; R7 no transfer while disabled
    wr(2'b01, 16'h0041);
    chk("R6 no sw start sel01", rdata[1], 0);
    wr(2'b01, 16'h0040);
    pulse(4'd0);
    wt(3);
    chk("R7 no valid disabled", valid, 0);
    chk("R7 pend kept", rdata[1], 1);
    wr(2'b01, 16'h0000);

    // normal mode: 16-bit, src inc, dst fixed, count 3
    sbase = 32'h100; dbase = 32'h200; cnt = 16'd3;
    wr(2'b01, 16'h0011);
    chk("R6 sw start sets", rdata[1], 1);
    sbase = 32'hDEAD; dbase = 32'hBEEF; cnt = 16'd9;
    wt(1);
    chk("R8 valid", valid, 1);
    chk("R8 pend clear on start", rdata[1], 0);
    chk("R13 src captured", src, 32'h100);
    chk("R9 halfword", byte_o, 0);
    wt(1);
    chk("R9 R10 src step 2", src, 32'h102);
    chk("R10 dst fixed", dst, 32'h200);
    wr(2'b01, 16'h0011); wt(2);
    chk("R10 src 2nd", src, 32'h104);
    chk("R11 still on", rdata[0], 1);
    wr(2'b01, 16'h0011); wt(2);
    chk("R10 src 3rd", src, 32'h106);
    chk("R11 enable off", rdata[0], 0);

    // ring mode: byte, both inc, count 2
    sbase = 32'h10; dbase = 32'h20; cnt = 16'd2;
    wr(2'b01, 16'h003D);
    sbase = 32'h777; dbase = 32'h777;
    wt(2);
    chk("R9 byte size", byte_o, 1);
    chk("R9 src step 1", src, 32'h11);
    chk("R10 dst inc", dst, 32'h21);
    wr(2'b01, 16'h003D); wt(2);
    chk("R12 src wrap", src, 32'h10);
    chk("R12 R13 dst wrap", dst, 32'h20);
    chk("R12 enable stays", rdata[0], 1);

    // R8 stall hold
    ready = 0;
    wr(2'b01, 16'h003D); wt(1);
    chk("R8 valid up", valid, 1);
    wt(3);
    chk("R8 valid held", valid, 1);
    chk("R8 src held", src, 32'h10);
    ready = 1; wt(1);
    chk("R8 released", valid, 0);
    chk("R12 after reload step", src, 32'h11);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule